// File: doc/BRIEF.md
# Indexed-Window Interrupt Redirection Controller

This block routes a set of external interrupt pins to interrupt messages. Software reaches its internal registers through a two-word window on a 32-bit register bus. The first word is an index register that selects an internal register. The second word is a data port that reads or writes the selected register. Each pin has a 64-bit redirection entry. The entry sets the vector, the destination, the active polarity, the trigger mode (edge or level) and a mask bit.

When an unmasked pin asserts according to its mode, the block presents a message on a valid/ready output. The message carries the vector, the destination and the trigger mode. Level-triggered pins use a remote-IRR handshake: after a message is delivered, the pin stays silent until an end-of-interrupt carrying the same vector is seen. The window itself can be moved to another 4 KiB-aligned base through an internal register.

Top module: `irq_router`

## Requirements
- R1: The index register is at window offset 0x00 and the data port at offset 0x10. A data-port access acts on the internal register whose number was last written to the index register. Read data appears on `busRdata` in the cycle after the read request. In every other cycle `busRdata` is zero, including reads at other offsets.
- R2: An access whose byte enables are not all set (`busByteEn != 4'hF`), or whose address bits 1:0 are not zero, changes no state and reads as zero.
- R3: Internal register 0x02 holds the window base. Its bits 31:12 are writable and its bits 11:0 read as zero. It resets to `BASE_RST` (0xFEC00000 by default). A write whose data has nonzero bits 11:0 is ignored. After a write, the window answers only at the new base.
- R4: Internal register 0x01 is read-only. It reads {8'h00, NUM_PINS-1, 8'h00, VERSION}, with VERSION = 8'h11 by default. Writes to it have no effect.
- R5: The entry for pin n is at index 0x10+2n (low word) and 0x11+2n (high word). The low word holds vector [7:0], polarity [13] (1 = active low), remote-IRR [14], trigger [15] (1 = level) and mask [16]. The high word holds destination [31:24]. All other bits read as zero.
- R6: After reset, every entry reads 0x00010000 (masked), the index register reads zero and `msgValid` is low.
- R7: In edge mode, an inactive-to-active transition on an unmasked pin latches one request. Further edges before that request is accepted merge into it. An edge on a masked pin is dropped and is not sent after unmasking.
- R8: In level mode, an active unmasked pin sends one message and sets remote-IRR on acceptance. The pin sends nothing more until `eoiValid` arrives with a matching `eoiVector`. If the pin is still active after that, the message is sent again.
- R9: A pin's active state is the pin level XOR its polarity bit.
- R10: When several pins have requests at once, the lowest-numbered pin is sent first.
- R11: A message holds vector, destination and trigger mode, and stays unchanged while `msgValid` is high and `msgReady` is low, even if the entry is rewritten.
- R12: Remote-IRR is read-only. Bus writes to bit 14 do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 32 | Byte address of the access |
| busByteEn | input | 4 | Byte enables |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| irqPin | input | NUM_PINS | Interrupt pins, synchronous to clk |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiVector | input | 8 | Vector carried by the end-of-interrupt |
| msgValid | output | 1 | Message available |
| msgReady | input | 1 | Receiver accepts the message |
| msgVector | output | 8 | Message vector |
| msgDest | output | 8 | Message destination |
| msgLevel | output | 1 | Message trigger mode, 1 = level |

## Verification
The bench builds the block with NUM_PINS = 4, so the version register reads 0x00030011 and the last entry word sits at index 0x17. With only four pins, the bench can give every pin its own role: pin 0 is edge-triggered with a held message, pin 1 is masked and then unmasked, pin 2 is level-triggered and exercises the EOI handshake, and pin 3 is active low. Pins 0 and 1 also collide to show the arbitration order. The default base is moved to 0xA0000000 so that both the old and the new window locations can be probed.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // internal register numbers reached through the index register
  localparam logic [7:0] REG_VER  = 8'h01;
  localparam logic [7:0] REG_BASE = 8'h02;
  localparam logic [7:0] REG_ENT0 = 8'h10;

  // offsets of the two bus-visible words inside the 4 KiB window page
  localparam logic [11:0] OFS_IDX = 12'h000;
  localparam logic [11:0] OFS_DAT = 12'h010;

  // strobes from control to datapath
  typedef struct packed {
    logic       idxWe;
    logic       baseWe;
    logic       entWe;
    logic       entHit;
    logic       entHi;
    logic [6:0] entSel;
    logic       rdIdx;
    logic       rdDat;
    logic       msgLoad;
    logic       msgAccept;
  } ctrl_strb_t;

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [31:0] busAddr,
  input  logic [3:0]  busByteEn,
  input  logic [7:0]  idxReg,
  input  logic [19:0] basePage,
  input  logic        anyReq,
  input  logic        msgValid,
  input  logic        msgReady,
  output ctrl_strb_t  strb
);

  localparam int ENT_END = 16 + 2 * NUM_PINS;

  logic       fullWord;
  logic       inWin;
  logic       atIdx;
  logic       atDat;
  logic [7:0] entOfs;

  always_comb begin
    fullWord = (busByteEn == 4'hF) && (busAddr[1:0] == 2'b00);
    inWin    = busValid && fullWord && (busAddr[31:12] == basePage);
    atIdx    = inWin && (busAddr[11:0] == OFS_IDX);
    atDat    = inWin && (busAddr[11:0] == OFS_DAT);
    entOfs   = idxReg - REG_ENT0;

    strb.idxWe     = atIdx && busWrite;
    strb.rdIdx     = atIdx && !busWrite;
    strb.rdDat     = atDat && !busWrite;
    strb.baseWe    = atDat && busWrite && (idxReg == REG_BASE);
    strb.entHit    = (idxReg >= REG_ENT0) && (int'(idxReg) < ENT_END);
    strb.entWe     = atDat && busWrite && strb.entHit;
    strb.entHi     = entOfs[0];
    strb.entSel    = entOfs[7:1];
    strb.msgLoad   = !msgValid && anyReq;
    strb.msgAccept = msgValid && msgReady;
  end

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int          NUM_PINS = 8,
  parameter logic [31:0] BASE_RST = 32'hFEC0_0000,
  parameter logic [7:0]  VERSION  = 8'h11
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strb_t          strb,
  input  logic [31:0]         busWdata,
  input  logic [NUM_PINS-1:0] irqPin,
  input  logic                eoiValid,
  input  logic [7:0]          eoiVector,
  output logic [7:0]          idxReg,
  output logic [19:0]         basePage,
  output logic                anyReq,
  output logic [31:0]         busRdata,
  output logic                msgValid,
  output logic [7:0]          msgVector,
  output logic [7:0]          msgDest,
  output logic                msgLevel
);

  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [7:0]          vecQ  [NUM_PINS];
  logic [7:0]          destQ [NUM_PINS];
  logic [NUM_PINS-1:0] polQ, trigQ, maskQ, rirrQ, pendQ, prevQ;
  logic [NUM_PINS-1:0] active, edgeHit, req;
  logic [PIN_W-1:0]    grant, msgPin, selPin;
  logic [31:0]         dataVal;

  // per-pin request qualification
  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      active[i]  = irqPin[i] ^ polQ[i];
      edgeHit[i] = active[i] && !prevQ[i] && !maskQ[i] && !trigQ[i];
      req[i]     = trigQ[i] ? (active[i] && !maskQ[i] && !rirrQ[i])
                            : (pendQ[i] && !maskQ[i]);
    end
  end

  // fixed priority: lowest pin number wins
  always_comb begin
    grant  = '0;
    anyReq = |req;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req[i]) grant = PIN_W'(i);
    end
  end

  // entry storage and pin state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        vecQ[i]  <= '0;
        destQ[i] <= '0;
      end
      polQ  <= '0;
      trigQ <= '0;
      maskQ <= '1;
      rirrQ <= '0;
      pendQ <= '0;
      prevQ <= '0;
    end else begin
      prevQ <= active;
      for (int i = 0; i < NUM_PINS; i++) begin
        if (strb.entWe && selPin == PIN_W'(i)) begin
          if (!strb.entHi) begin
            vecQ[i]  <= busWdata[7:0];
            polQ[i]  <= busWdata[13];
            trigQ[i] <= busWdata[15];
            maskQ[i] <= busWdata[16];
          end else begin
            destQ[i] <= busWdata[31:24];
          end
        end
        if (edgeHit[i])
          pendQ[i] <= 1'b1;
        else if (strb.msgAccept && msgPin == PIN_W'(i) && !msgLevel)
          pendQ[i] <= 1'b0;
        if (strb.msgAccept && msgPin == PIN_W'(i) && msgLevel)
          rirrQ[i] <= 1'b1;
        else if (eoiValid && trigQ[i] && vecQ[i] == eoiVector)
          rirrQ[i] <= 1'b0;
      end
    end
  end

  // window registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg   <= '0;
      basePage <= BASE_RST[31:12];
    end else begin
      if (strb.idxWe) idxReg <= busWdata[7:0];
      if (strb.baseWe && busWdata[11:0] == 12'h000) basePage <= busWdata[31:12];
    end
  end

  // data-port read mux
  always_comb begin
    dataVal = '0;
    selPin  = PIN_W'(strb.entSel);
    if (idxReg == REG_VER)
      dataVal = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};
    else if (idxReg == REG_BASE)
      dataVal = {basePage, 12'h000};
    else if (strb.entHit) begin
      if (!strb.entHi)
        dataVal = {15'b0, maskQ[selPin], trigQ[selPin], rirrQ[selPin],
                   polQ[selPin], 5'b0, vecQ[selPin]};
      else
        dataVal = {destQ[selPin], 24'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            busRdata <= '0;
    else if (strb.rdIdx)  busRdata <= {24'b0, idxReg};
    else if (strb.rdDat)  busRdata <= dataVal;
    else                  busRdata <= '0;
  end

  // outgoing message slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid  <= 1'b0;
      msgVector <= '0;
      msgDest   <= '0;
      msgLevel  <= 1'b0;
      msgPin    <= '0;
    end else if (strb.msgLoad) begin
      msgValid  <= 1'b1;
      msgVector <= vecQ[grant];
      msgDest   <= destQ[grant];
      msgLevel  <= trigQ[grant];
      msgPin    <= grant;
    end else if (strb.msgAccept) begin
      msgValid  <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int          NUM_PINS = 8,
  parameter logic [31:0] BASE_RST = 32'hFEC0_0000,
  parameter logic [7:0]  VERSION  = 8'h11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [31:0]         busAddr,
  input  logic [3:0]          busByteEn,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_PINS-1:0] irqPin,
  input  logic                eoiValid,
  input  logic [7:0]          eoiVector,
  output logic                msgValid,
  input  logic                msgReady,
  output logic [7:0]          msgVector,
  output logic [7:0]          msgDest,
  output logic                msgLevel
);

  ctrl_strb_t  strb;
  logic [7:0]  idxReg;
  logic [19:0] basePage;
  logic        anyReq;

  irq_router_ctrl #(.NUM_PINS(NUM_PINS)) uCtrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busByteEn(busByteEn),
    .idxReg   (idxReg),
    .basePage (basePage),
    .anyReq   (anyReq),
    .msgValid (msgValid),
    .msgReady (msgReady),
    .strb     (strb)
  );

  irq_router_dp #(
    .NUM_PINS(NUM_PINS),
    .BASE_RST(BASE_RST),
    .VERSION (VERSION)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .irqPin   (irqPin),
    .eoiValid (eoiValid),
    .eoiVector(eoiVector),
    .idxReg   (idxReg),
    .basePage (basePage),
    .anyReq   (anyReq),
    .busRdata (busRdata),
    .msgValid (msgValid),
    .msgVector(msgVector),
    .msgDest  (msgDest),
    .msgLevel (msgLevel)
  );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int         NUM_PINS = 8,
  parameter logic [7:0] VERSION  = 8'h11
) (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic        busWrite,
  input logic [31:0] busAddr,
  input logic [3:0]  busByteEn,
  input logic [31:0] busRdata,
  input logic        msgValid,
  input logic        msgReady,
  input logic [7:0]  msgVector,
  input logic [7:0]  msgDest,
  input logic        msgLevel,
  input logic [7:0]  idxReg,
  input logic [19:0] basePage
);

  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};

  // R11
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgVector) && $stable(msgDest) && $stable(msgLevel));

  // R11
  msg_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgReady |=> !msgValid);

  // R2
  bad_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && (busByteEn != 4'hF || busAddr[1:0] != 2'b00) |=> busRdata == 32'h0);

  // R1
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> busRdata == 32'h0);

  // R4
  version_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busWrite && busByteEn == 4'hF && busAddr == {basePage, 12'h010} && idxReg == 8'h01
    |=> busRdata == VER_WORD);

endmodule

bind irq_router irq_router_chk #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busValid (busValid),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busByteEn(busByteEn),
  .busRdata (busRdata),
  .msgValid (msgValid),
  .msgReady (msgReady),
  .msgVector(msgVector),
  .msgDest  (msgDest),
  .msgLevel (msgLevel),
  .idxReg   (idxReg),
  .basePage (basePage)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;

  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busValid = 1'b0;
  logic          busWrite = 1'b0;
  logic [31:0]   busAddr = '0;
  logic [3:0]    busByteEn = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [N-1:0]  irqPin = '0;
  logic          eoiValid = 1'b0;
  logic [7:0]    eoiVector = '0;
  logic          msgValid;
  logic          msgReady = 1'b0;
  logic [7:0]    msgVector;
  logic [7:0]    msgDest;
  logic          msgLevel;

  int            total = 0;
  int            bad = 0;
  bit            finished = 0;
  logic [31:0]   curBase = 32'hFEC0_0000;

  always #4 clk = ~clk;

  irq_router #(.NUM_PINS(N)) u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWdata(busWdata),
    .busRdata(busRdata), .irqPin(irqPin), .eoiValid(eoiValid),
    .eoiVector(eoiVector), .msgValid(msgValid), .msgReady(msgReady),
    .msgVector(msgVector), .msgDest(msgDest), .msgLevel(msgLevel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic busAcc(input logic wr, input logic [31:0] addr, input logic [31:0] wdata,
                        input logic [3:0] be, output logic [31:0] rdata);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = addr; busWdata = wdata; busByteEn = be;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    rdata = busRdata;
  endtask

  task automatic regWr(input logic [7:0] idx, input logic [31:0] val);
    logic [31:0] d;
    busAcc(1'b1, curBase, {24'b0, idx}, 4'hF, d);
    busAcc(1'b1, curBase + 32'h10, val, 4'hF, d);
  endtask

  task automatic regRd(input logic [7:0] idx, output logic [31:0] val);
    logic [31:0] d;
    busAcc(1'b1, curBase, {24'b0, idx}, 4'hF, d);
    busAcc(1'b0, curBase + 32'h10, 32'h0, 4'hF, val);
  endtask

  task automatic waitMsg(input int n, output bit got);
    got = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (msgValid) begin
        got = 1;
        break;
      end
    end
  endtask

  task automatic acceptMsg();
    @(negedge clk); msgReady = 1'b1;
    @(negedge clk); msgReady = 1'b0;
  endtask

  task automatic pulsePin(input int p);
    @(negedge clk); irqPin[p] = 1'b1;
    @(negedge clk); irqPin[p] = 1'b0;
  endtask

  task automatic sendEoi(input logic [7:0] v);
    @(negedge clk); eoiValid = 1'b1; eoiVector = v;
    @(negedge clk); eoiValid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R6 msgValid", {31'b0, msgValid}, 32'h0);
    busAcc(1'b0, curBase, 32'h0, 4'hF, d);
    chk("R6 index", d, 32'h0);
    regRd(8'h16, d);
    chk("R6 entry3 low", d, 32'h0001_0000);
    regRd(8'h02, d);
    chk("R3 base reset", d, 32'hFEC0_0000);
  endtask

  task automatic t_version();
    logic [31:0] d;
    regRd(8'h01, d);
    chk("R4 version", d, 32'h0003_0011);
    regWr(8'h01, 32'hFFFF_FFFF);
    regRd(8'h01, d);
    chk("R4 read-only", d, 32'h0003_0011);
  endtask

  task automatic t_window();
    logic [31:0] d;
    busAcc(1'b1, curBase, 32'h11, 4'hF, d);
    busAcc(1'b0, curBase, 32'h0, 4'hF, d);
    chk("R1 index readback", d, 32'h11);
    busAcc(1'b1, curBase + 32'h2, 32'h12, 4'hF, d);
    busAcc(1'b0, curBase, 32'h0, 4'hF, d);
    chk("R2 misaligned write", d, 32'h11);
    busAcc(1'b1, curBase, 32'h13, 4'h3, d);
    busAcc(1'b0, curBase, 32'h0, 4'hF, d);
    chk("R2 partial write", d, 32'h11);
    busAcc(1'b0, curBase, 32'h0, 4'h3, d);
    chk("R2 partial read", d, 32'h0);
    busAcc(1'b0, curBase + 32'h20, 32'h0, 4'hF, d);
    chk("R1 other offset", d, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    regWr(8'h12, 32'h0001_C0C5);
    regRd(8'h12, d);
    chk("R5 R12 entry1 low", d, 32'h0001_80C5);
    regWr(8'h13, 32'hAB00_00FF);
    regRd(8'h13, d);
    chk("R5 entry1 high", d, 32'hAB00_0000);
    regWr(8'h12, 32'h0001_0042);
  endtask

  task automatic t_edge();
    bit got;
    regWr(8'h10, 32'h0000_0031);
    regWr(8'h11, 32'h0500_0000);
    pulsePin(0);
    waitMsg(10, got);
    chk("R7 edge message", {31'b0, got}, 32'h1);
    chk("R11 vector", {24'b0, msgVector}, 32'h31);
    chk("R11 dest", {24'b0, msgDest}, 32'h05);
    chk("R11 level flag", {31'b0, msgLevel}, 32'h0);
    pulsePin(0);
    pulsePin(0);
    regWr(8'h10, 32'h0000_0033);
    chk("R11 held valid", {31'b0, msgValid}, 32'h1);
    chk("R11 held vector", {24'b0, msgVector}, 32'h31);
    regWr(8'h10, 32'h0000_0031);
    acceptMsg();
    waitMsg(10, got);
    chk("R7 merged edges", {31'b0, got}, 32'h0);
  endtask

  task automatic t_mask();
    bit got;
    pulsePin(1);
    waitMsg(10, got);
    chk("R7 masked edge", {31'b0, got}, 32'h0);
    regWr(8'h12, 32'h0000_0042);
    waitMsg(10, got);
    chk("R7 dropped after unmask", {31'b0, got}, 32'h0);
  endtask

  task automatic t_level();
    bit got;
    logic [31:0] d;
    regWr(8'h14, 32'h0000_8050);
    regWr(8'h15, 32'h0200_0000);
    @(negedge clk); irqPin[2] = 1'b1;
    waitMsg(10, got);
    chk("R8 level message", {31'b0, got}, 32'h1);
    chk("R8 vector", {24'b0, msgVector}, 32'h50);
    chk("R11 level flag", {31'b0, msgLevel}, 32'h1);
    acceptMsg();
    regRd(8'h14, d);
    chk("R8 remote-IRR set", d, 32'h0000_C050);
    waitMsg(10, got);
    chk("R8 silent until EOI", {31'b0, got}, 32'h0);
    regWr(8'h14, 32'h0000_8050);
    regRd(8'h14, d);
    chk("R12 remote-IRR write", d, 32'h0000_C050);
    sendEoi(8'h51);
    waitMsg(10, got);
    chk("R8 wrong vector EOI", {31'b0, got}, 32'h0);
    sendEoi(8'h50);
    waitMsg(10, got);
    chk("R8 resend after EOI", {31'b0, got}, 32'h1);
    chk("R8 resend vector", {24'b0, msgVector}, 32'h50);
    acceptMsg();
    @(negedge clk); irqPin[2] = 1'b0;
    sendEoi(8'h50);
    waitMsg(10, got);
    chk("R8 inactive after EOI", {31'b0, got}, 32'h0);
    regRd(8'h14, d);
    chk("R8 remote-IRR cleared", d, 32'h0000_8050);
  endtask

  task automatic t_priority();
    bit got;
    @(negedge clk); irqPin[0] = 1'b1; irqPin[1] = 1'b1;
    @(negedge clk); irqPin[0] = 1'b0; irqPin[1] = 1'b0;
    waitMsg(10, got);
    chk("R10 first", {23'b0, got, msgVector}, {23'b0, 1'b1, 8'h31});
    acceptMsg();
    waitMsg(10, got);
    chk("R10 second", {23'b0, got, msgVector}, {23'b0, 1'b1, 8'h42});
    acceptMsg();
  endtask

  task automatic t_polarity();
    bit got;
    @(negedge clk); irqPin[3] = 1'b1;
    regWr(8'h16, 32'h0000_2060);
    waitMsg(10, got);
    chk("R9 high is inactive", {31'b0, got}, 32'h0);
    @(negedge clk); irqPin[3] = 1'b0;
    waitMsg(10, got);
    chk("R9 falling pin sends", {23'b0, got, msgVector}, {23'b0, 1'b1, 8'h60});
    acceptMsg();
    @(negedge clk); irqPin[3] = 1'b1;
    waitMsg(10, got);
    chk("R9 rising pin silent", {31'b0, got}, 32'h0);
  endtask

  task automatic t_reloc();
    logic [31:0] d;
    logic [31:0] oldBase;
    regWr(8'h02, 32'hA000_0123);
    regRd(8'h02, d);
    chk("R3 unaligned base ignored", d, 32'hFEC0_0000);
    regWr(8'h02, 32'hA000_0000);
    oldBase = curBase;
    curBase = 32'hA000_0000;
    busAcc(1'b0, oldBase, 32'h0, 4'hF, d);
    chk("R3 old base silent", d, 32'h0);
    regRd(8'h02, d);
    chk("R3 new base", d, 32'hA000_0000);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_version();
    t_window();
    t_layout();
    t_edge();
    t_mask();
    t_level();
    t_priority();
    t_polarity();
    t_reloc();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule